// File: doc/BRIEF.md
# Multiprocessor UART Address Filter

This block sits behind the receiver of a 9-bit multiprocessor serial link and decides, frame by frame, whether the traffic on the shared line is meant for this node. Frames arrive already deserialized, one per cycle of `frame_valid_i`. Bit 8 of the frame is the kind bit. When it is 1 the low byte is an address. When it is 0 the low byte is data.

Each node holds an address register and a mask register. An address frame selects the node in either of two cases. The first is a masked match: every bit where the mask is 1 equals the address register. The second is a broadcast match: the frame has a 1 wherever the OR of address and mask has a 1. A selecting frame produces a one-cycle accept pulse, which is the receive interrupt, and sets the selected state. A non-selecting address frame clears that state. Data frames are passed on only while the node is selected. With both registers at zero every address matches, so filtering is effectively off. Giving each node its own low address bit as a don't-care lets one address frame select a group of nodes.

Top module: `uart_addr_filter`

## Requirements
- R1: After reset, `accept_o`, `selected_o` and `data_valid_o` are 0, and `data_o` is 0.
- R2: An address frame (bit 8 = 1) whose low byte equals `node_addr_i` in every bit where `node_mask_i` is 1 pulses `accept_o` in the cycle after the frame is presented. Bits where the mask is 0 are don't-care, so one address can select several nodes at once.
- R3: An address frame whose low byte has a 1 in every bit where (`node_addr_i` | `node_mask_i`) is 1 is accepted as a broadcast, even when the masked match of R2 fails.
- R4: With `node_addr_i` = 0 and `node_mask_i` = 0, every address frame is accepted.
- R5: An accepted address frame sets `selected_o` in the cycle after the frame. An address frame that is not accepted clears `selected_o`.
- R6: A data frame (bit 8 = 0) presented while `selected_o` is 1 produces a one-cycle `data_valid_o` pulse in the next cycle, with `data_o` equal to the frame's low byte. A data frame never pulses `accept_o` and never changes `selected_o`.
- R7: A data frame presented while `selected_o` is 0 is ignored: `data_valid_o` stays 0 and `selected_o` stays 0.
- R8: Without `frame_valid_i`, `frame_i` has no effect: `accept_o` and `data_valid_o` are 0 in the next cycle and `selected_o` holds its value. `accept_o` stays high for one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| frame_valid_i | input | 1 | A received frame is present this cycle |
| frame_i | input | 9 | Received frame: bit 8 is the kind bit (1 = address), bits 7:0 are the payload |
| node_addr_i | input | 8 | Node address register |
| node_mask_i | input | 8 | Address mask register; a 1 marks a bit that must match |
| accept_o | output | 1 | One-cycle pulse when an address frame selects this node |
| selected_o | output | 1 | Node is currently selected |
| data_valid_o | output | 1 | One-cycle pulse for a data frame passed to this node |
| data_o | output | 8 | Payload of the passed data frame |

## Verification
Three nodes run side by side. Their address and mask pairs give the don't-care patterns 1100_0xx0, 1110_0x0x and 1100_00xx. Address frames are chosen to tell the two match paths apart. Some frames hit one node only through the masked match, some hit a group of nodes at once (0xC0 selects the first and third), some hit only through a node's broadcast pattern (0xF9, 0xFA, 0xFC), 0xFF hits all three nodes, and some hit no node. After each address frame a data frame shows whether the selected state follows the decision. Directed cases cover the open setting with both registers cleared, deselection by a foreign address, and a frame held on the bus with the valid strobe low.

// File: rtl/uaf_pkg.sv
package uaf_pkg;
    localparam int unsigned UAF_DATA_W = 8;

    typedef enum logic [0:0] {
        FR_DATA = 1'b0,
        FR_ADDR = 1'b1
    } frame_kind_e;
endpackage

// File: rtl/uaf_bit_match.sv
// Per-bit compare of a payload against a reference, restricted to care bits.
module uaf_bit_match #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] data_i,
    input  logic [W-1:0] ref_i,
    input  logic [W-1:0] care_i,
    output logic         hit_o
);
    logic [W-1:0] miss;

    for (genvar b = 0; b < W; b++) begin : g_bit
        assign miss[b] = care_i[b] & (data_i[b] ^ ref_i[b]);
    end

    assign hit_o = ~|miss;
endmodule

// File: rtl/uaf_sel_ctrl.sv
// Selection state and output registers of the address filter.
module uaf_sel_ctrl
    import uaf_pkg::*;
#(
    parameter int unsigned W = UAF_DATA_W
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         valid_i,
    input  frame_kind_e  kind_i,
    input  logic [W-1:0] payload_i,
    input  logic         addr_hit_i,
    output logic         accept_o,
    output logic         selected_o,
    output logic         data_valid_o,
    output logic [W-1:0] data_o
);
    typedef struct packed {
        logic         accept;
        logic         sel;
        logic         dvalid;
        logic [W-1:0] data;
    } sel_state_t;

    sel_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.accept = 1'b0;
        st_d.dvalid = 1'b0;
        if (valid_i) begin
            if (kind_i == FR_ADDR) begin
                st_d.accept = addr_hit_i;
                st_d.sel    = addr_hit_i;
            end else if (st_q.sel) begin
                st_d.dvalid = 1'b1;
                st_d.data   = payload_i;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign accept_o     = st_q.accept;
    assign selected_o   = st_q.sel;
    assign data_valid_o = st_q.dvalid;
    assign data_o       = st_q.data;

    a_r5_accept_selects: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accept_o |-> selected_o);

    a_r6_no_dual_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(accept_o && data_valid_o));

    a_r7_data_needs_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && kind_i == FR_DATA && !selected_o) |=> (!data_valid_o && !selected_o));

    a_r6_data_keeps_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && kind_i == FR_DATA) |=> $stable(selected_o));

    a_r8_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> (!accept_o && !data_valid_o && $stable(selected_o)));

    a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accept_o |-> $past(valid_i && kind_i == FR_ADDR));
endmodule

// File: rtl/uart_addr_filter.sv
// Address recognition filter for a 9-bit multiprocessor UART receiver.
module uart_addr_filter
    import uaf_pkg::*;
#(
    parameter int unsigned DATA_W = UAF_DATA_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              frame_valid_i,
    input  logic [DATA_W:0]   frame_i,
    input  logic [DATA_W-1:0] node_addr_i,
    input  logic [DATA_W-1:0] node_mask_i,
    output logic              accept_o,
    output logic              selected_o,
    output logic              data_valid_o,
    output logic [DATA_W-1:0] data_o
);
    localparam logic [DATA_W-1:0] ALL_ONES = '1;

    logic [DATA_W-1:0] payload;
    logic [DATA_W-1:0] bcast_care;
    frame_kind_e       kind;
    logic              given_hit;
    logic              bcast_hit;

    assign payload    = frame_i[DATA_W-1:0];
    assign kind       = frame_kind_e'(frame_i[DATA_W]);
    assign bcast_care = node_addr_i | node_mask_i;

    uaf_bit_match #(.W(DATA_W)) u_given (
        .data_i (payload),
        .ref_i  (node_addr_i),
        .care_i (node_mask_i),
        .hit_o  (given_hit)
    );

    uaf_bit_match #(.W(DATA_W)) u_bcast (
        .data_i (payload),
        .ref_i  (ALL_ONES),
        .care_i (bcast_care),
        .hit_o  (bcast_hit)
    );

    uaf_sel_ctrl #(.W(DATA_W)) u_ctrl (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .valid_i      (frame_valid_i),
        .kind_i       (kind),
        .payload_i    (payload),
        .addr_hit_i   (given_hit | bcast_hit),
        .accept_o     (accept_o),
        .selected_o   (selected_o),
        .data_valid_o (data_valid_o),
        .data_o       (data_o)
    );

    a_r4_open_filter: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (frame_valid_i && frame_i[DATA_W] && node_addr_i == '0 && node_mask_i == '0)
        |=> accept_o);

    a_r3_all_ones_broadcast: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (frame_valid_i && frame_i[DATA_W] && payload == ALL_ONES) |=> accept_o);

    a_r6_data_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        data_valid_o |-> (data_o == $past(payload)));
endmodule

// File: tb/uart_addr_filter_tb_top.sv
`timescale 1ns/1ps
module uart_addr_filter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fvalid = 1'b0;
    logic [8:0] frame = '0;
    logic [7:0] naddr [3];
    logic [7:0] nmask [3];
    logic [2:0] acc, sel, dv;
    logic [7:0] dout [3];
    int         checks = 0;
    int         fails = 0;

    always #2 clk = ~clk;

    uart_addr_filter dut_i (
        .clk_i(clk), .rst_ni(rst_n), .frame_valid_i(fvalid), .frame_i(frame),
        .node_addr_i(naddr[0]), .node_mask_i(nmask[0]),
        .accept_o(acc[0]), .selected_o(sel[0]), .data_valid_o(dv[0]), .data_o(dout[0]));
    uart_addr_filter dut_s1_i (
        .clk_i(clk), .rst_ni(rst_n), .frame_valid_i(fvalid), .frame_i(frame),
        .node_addr_i(naddr[1]), .node_mask_i(nmask[1]),
        .accept_o(acc[1]), .selected_o(sel[1]), .data_valid_o(dv[1]), .data_o(dout[1]));
    uart_addr_filter dut_s2_i (
        .clk_i(clk), .rst_ni(rst_n), .frame_valid_i(fvalid), .frame_i(frame),
        .node_addr_i(naddr[2]), .node_mask_i(nmask[2]),
        .accept_o(acc[2]), .selected_o(sel[2]), .data_valid_o(dv[2]), .data_o(dout[2]));

    // {address byte, expected accept for nodes 2,1,0}
    localparam int NVEC = 11;
    localparam logic [10:0] VEC [NVEC] = '{
        {8'hC0, 3'b101}, {8'hC2, 3'b101}, {8'hC4, 3'b001}, {8'hC1, 3'b100},
        {8'hE0, 3'b010}, {8'hE2, 3'b000}, {8'hFF, 3'b111}, {8'hF9, 3'b001},
        {8'hFC, 3'b100}, {8'hFA, 3'b010}, {8'h00, 3'b000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic kind, input logic [7:0] b);
        @(negedge clk);
        fvalid = 1'b1;
        frame  = {kind, b};
        @(negedge clk);
        fvalid = 1'b0;
    endtask

    initial begin
        naddr[0] = 8'hC0; nmask[0] = 8'hF9;
        naddr[1] = 8'hE0; nmask[1] = 8'hFA;
        naddr[2] = 8'hC0; nmask[2] = 8'hFC;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 accept", {29'd0, acc}, 32'd0);
        chk("R1 selected", {29'd0, sel}, 32'd0);
        chk("R1 data_valid", {29'd0, dv}, 32'd0);
        chk("R1 data", {24'd0, dout[0]}, 32'd0);

        // R2/R3/R5/R6/R7: address table followed by a data frame each
        for (int v = 0; v < NVEC; v++) begin
            logic [7:0] a;
            logic [2:0] e;
            a = VEC[v][10:3];
            e = VEC[v][2:0];
            send(1'b1, a);
            chk($sformatf("R2/R3 accept addr %0h", a), {29'd0, acc}, {29'd0, e});
            chk($sformatf("R5 selected addr %0h", a), {29'd0, sel}, {29'd0, e});
            send(1'b0, 8'h5A ^ a);
            chk($sformatf("R6/R7 data_valid after %0h", a), {29'd0, dv}, {29'd0, e});
            chk("R6 no accept on data", {29'd0, acc}, 32'd0);
            chk("R6/R7 selected kept", {29'd0, sel}, {29'd0, e});
            for (int n = 0; n < 3; n++) begin
                if (e[n]) chk($sformatf("R6 data node %0d", n), {24'd0, dout[n]}, {24'd0, 8'h5A ^ a});
            end
        end

        // R5/R7: deselect node 1 with a foreign address, then data is ignored
        send(1'b1, 8'hE0);
        chk("R5 node1 selected", {31'd0, sel[1]}, 32'd1);
        send(1'b1, 8'hE2);
        chk("R5 node1 deselected", {31'd0, sel[1]}, 32'd0);
        send(1'b0, 8'h33);
        chk("R7 node1 data ignored", {31'd0, dv[1]}, 32'd0);

        // R8: frame on the bus with valid low, and pulse width
        send(1'b1, 8'hFF);
        chk("R8 accept pulse", {29'd0, acc}, 32'd7);
        @(negedge clk);
        chk("R8 accept one cycle", {29'd0, acc}, 32'd0);
        frame = {1'b1, 8'h00};
        repeat (3) @(negedge clk);
        chk("R8 idle selected held", {29'd0, sel}, 32'd7);
        chk("R8 idle no accept", {29'd0, acc}, 32'd0);
        frame = {1'b0, 8'h77};
        repeat (2) @(negedge clk);
        chk("R8 idle no data", {29'd0, dv}, 32'd0);

        // R4: cleared registers accept any address
        naddr[0] = 8'h00; nmask[0] = 8'h00;
        send(1'b1, 8'h37);
        chk("R4 open accept 37", {31'd0, acc[0]}, 32'd1);
        send(1'b1, 8'h00);
        chk("R4 open accept 00", {31'd0, acc[0]}, 32'd1);
        chk("R4 others reject 00", {30'd0, acc[2:1]}, 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule